// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets logic in a synchronous clock domain read and write an asynchronous static RAM. The host hands over one request at a time: an address, write data and a direction flag, under a valid/ready handshake. The controller then runs the access on the memory pins as three timed phases: setup, strobe and hold. It returns read data with a one-cycle response pulse.

Each phase length comes from a configuration register that can be written at any time. Reads and writes have their own setup, strobe and hold fields. A separate turnaround count adds idle cycles before a write that directly follows a read. This gives a slow memory time to release the data bus before the controller starts driving it. A new register value is copied into the controller only when the next access starts, so a change never alters an access that is already running.

The data bus is split into an output value, an output enable and an input value. An IO pad at the chip edge joins them into one tristate line.

Top module: `asram_ctrl`

## Requirements
- R1: A read drives three back-to-back phases lasting (read setup + 1), (read strobe + 1) and (read hold + 1) clock cycles. Output enable is low only during the strobe phase.
- R2: A write uses the write setup, strobe and hold fields, each also encoded as cycles minus one. Write enable is low only during the write strobe phase. Output enable and write enable are never low together.
- R3: Read data is the bus value at the clock edge that ends the strobe phase, which is the edge where output enable rises. It is presented with a one-cycle response pulse in the first cycle after the hold phase.
- R4: A write whose previous access was a read is preceded by (turnaround + 1) idle cycles with chip enable high and the bus not driven. Read-to-read, write-to-write and write-to-read sequences get no idle cycles. The controller never drives the bus while the memory may still be driving it.
- R5: The bus driver is enabled exactly from the first write setup cycle through the last write hold cycle, carrying the request's write data. It is never enabled during a read or during turnaround.
- R6: Chip enable is low from the first setup cycle through the last hold cycle. The memory address equals the request address and holds steady for the whole access.
- R7: Ready is high only while the controller is idle. A request is taken at a clock edge where valid and ready are both high, and ready is low from that edge until the access completes.
- R8: Configuration writes take effect at the start of the next access, never during one. The 28-bit layout is: turnaround [27:24], write setup [23:20], write strobe [19:16], write hold [15:12], read setup [11:8], read strobe [7:4], read hold [3:0]. The reset value has every field at 15.
- R9: During and right after reset, chip enable, output enable and write enable are high, the bus driver is off, ready is high and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load the configuration register |
| cfg_data | input | 28 | New configuration value (layout in R8) |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 16 | Data bus value driven by the controller |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 16 | Data bus value seen at the pins |

## Verification
The assertions check, on every cycle, the relations between the pin strobes that must hold whatever the timing values are:
- output enable and write enable are never low together;
- neither strobe is active without chip enable;
- the driver is on during the write strobe;
- the address stays steady while chip enable is low;
- the response follows the end of an access;
- ready appears only while the memory is deselected.

Only the bench scenarios can show the rest. These are:
- the exact phase lengths for each field value;
- that turnaround appears for read-then-write and only there;
- that a short strobe against a slow memory yields invalid data;
- that a configuration write during an access is held back until the next one.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    localparam int TIM_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_TURN   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [TIM_W-1:0] setup;
        logic [TIM_W-1:0] strobe;
        logic [TIM_W-1:0] hold;
    } phase_tim_t;

    typedef struct packed {
        logic [TIM_W-1:0] turn;
        phase_tim_t       wr;
        phase_tim_t       rd;
    } asram_cfg_t;

    localparam int CFG_W = $bits(asram_cfg_t);
    localparam asram_cfg_t CFG_RESET = '1;

    function automatic logic in_access(phase_e p);
        return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
    endfunction

    function automatic phase_tim_t pick_tim(asram_cfg_t c, logic wr);
        return wr ? c.wr : c.rd;
    endfunction

endpackage

// File: rtl/asram_cfg_reg.sv
`timescale 1ns/1ps
module asram_cfg_reg
    import asram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    output asram_cfg_t       cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_wr) begin
            cfg_q <= asram_cfg_t'(cfg_data);
        end
    end

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
    import asram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_wr,
    input  asram_cfg_t cfg,
    output phase_e     phase,
    output logic       is_wr,
    output logic       strobe_end,
    output logic       hold_end
);

    logic [TIM_W-1:0] cnt;
    phase_tim_t       tim_q;
    phase_tim_t       sel_tim;
    logic             last_rd;
    logic             need_turn;
    logic             cnt_zero;

    assign sel_tim    = pick_tim(cfg, start_wr);
    assign need_turn  = start_wr && last_rd;
    assign cnt_zero   = (cnt == '0);
    assign strobe_end = (phase == PH_STROBE) && cnt_zero;
    assign hold_end   = (phase == PH_HOLD) && cnt_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            tim_q   <= '0;
            is_wr   <= 1'b0;
            last_rd <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        is_wr <= start_wr;
                        tim_q <= sel_tim;
                        if (need_turn) begin
                            phase <= PH_TURN;
                            cnt   <= cfg.turn;
                        end else begin
                            phase <= PH_SETUP;
                            cnt   <= sel_tim.setup;
                        end
                    end
                end
                PH_TURN: begin
                    if (cnt_zero) begin
                        phase <= PH_SETUP;
                        cnt   <= tim_q.setup;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase <= PH_STROBE;
                        cnt   <= tim_q.strobe;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt_zero) begin
                        phase <= PH_HOLD;
                        cnt   <= tim_q.hold;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) begin
                        phase   <= PH_IDLE;
                        last_rd <= !is_wr;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/asram_pins.sv
`timescale 1ns/1ps
module asram_pins
    import asram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase,
    input  logic              is_wr,
    input  logic              strobe_end,
    input  logic              hold_end,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              active;
    logic              strobing;

    assign active   = in_access(phase);
    assign strobing = (phase == PH_STROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_rdata <= '0;
            rsp_valid <= 1'b0;
        end else begin
            if (start) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (strobe_end && !is_wr) begin
                rsp_rdata <= dq_in;
            end
            rsp_valid <= hold_end && !is_wr;
        end
    end

    assign mem_addr = addr_q;
    assign ce_n     = !active;
    assign oe_n     = !(strobing && !is_wr);
    assign we_n     = !(strobing && is_wr);
    assign dq_oe    = active && is_wr;
    assign dq_out   = wdata_q;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    asram_cfg_t cfg_q;
    phase_e     phase;
    logic       is_wr;
    logic       strobe_end;
    logic       hold_end;
    logic       start;

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;

    asram_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .cfg_q    (cfg_q)
    );

    asram_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_wr   (req_write),
        .cfg        (cfg_q),
        .phase      (phase),
        .is_wr      (is_wr),
        .strobe_end (strobe_end),
        .hold_end   (hold_end)
    );

    asram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .phase      (phase),
        .is_wr      (is_wr),
        .strobe_end (strobe_end),
        .hold_end   (hold_end),
        .dq_in      (mem_dq_in),
        .mem_addr   (mem_addr),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .dq_out     (mem_dq_out),
        .dq_oe      (mem_dq_oe),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    assert_oe_needs_ce_R1: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n);

    assert_we_with_driver_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_dq_oe && !mem_ce_n));

    assert_driver_not_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    assert_addr_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    assert_ready_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n);

    assert_rsp_after_access_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (mem_ce_n && $past(!mem_ce_n) && $past(mem_oe_n)));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;
    import asram_pkg::*;

    localparam real CLK_P   = 5.0;
    localparam int  MEM_ACC = 2;
    localparam int  MEM_OFF = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_data = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [15:0]      req_addr = '0;
    logic [15:0]      req_wdata = '0;
    logic             rsp_valid;
    logic [15:0]      rsp_rdata;
    logic [15:0]      mem_addr;
    logic             mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [15:0]      mem_dq_out;
    logic [15:0]      mem_dq_in = 16'hBAD0;

    always #(CLK_P/2) clk = ~clk;

    asram_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int    checks = 0;
    int    errors = 0;
    string scen = "reset";

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s [%s] actual=%0h expected=%0h t=%0t", tag, what, scen, act, exp, $time);
        end
    endtask

    typedef struct {
        bit          ce_n, oe_n, we_n, dq_oe, ready, rsp;
        logic [15:0] addr, wdata, rdata;
        string       tag;
    } exp_t;

    exp_t        q[$];
    asram_cfg_t  mcfg;
    bit          m_last_rd;
    logic [15:0] ref_mem [16];
    logic [15:0] sram    [16];
    int          oe_cnt;
    int          off_cnt;

    function automatic exp_t idle_e();
        exp_t e;
        e.ce_n = 1; e.oe_n = 1; e.we_n = 1; e.dq_oe = 0; e.ready = 1; e.rsp = 0;
        e.addr = '0; e.wdata = '0; e.rdata = '0; e.tag = "R7";
        return e;
    endfunction

    task automatic push_access(bit wr, logic [15:0] a, logic [15:0] d);
        exp_t e;
        int su, st, hd;
        su = wr ? int'(mcfg.wr.setup)  : int'(mcfg.rd.setup);
        st = wr ? int'(mcfg.wr.strobe) : int'(mcfg.rd.strobe);
        hd = wr ? int'(mcfg.wr.hold)   : int'(mcfg.rd.hold);
        if (wr && m_last_rd) begin
            for (int i = 0; i <= int'(mcfg.turn); i++) begin
                e = idle_e(); e.ready = 0; e.tag = "R4";
                q.push_back(e);
            end
        end
        e = idle_e();
        e.ce_n = 0; e.ready = 0; e.dq_oe = wr; e.addr = a; e.wdata = d;
        e.tag = wr ? "R2" : "R1";
        for (int i = 0; i <= su; i++) q.push_back(e);
        e.oe_n = wr; e.we_n = !wr;
        for (int i = 0; i <= st; i++) q.push_back(e);
        e.oe_n = 1; e.we_n = 1;
        for (int i = 0; i <= hd; i++) q.push_back(e);
        if (!wr) begin
            e = idle_e(); e.rsp = 1; e.tag = "R3";
            e.rdata = (st + 1 > MEM_ACC) ? ref_mem[a[3:0]] : 16'hBAD0;
            q.push_back(e);
        end else begin
            ref_mem[a[3:0]] = d;
        end
        m_last_rd = !wr;
    endtask

    task automatic compare(exp_t e);
        check(mem_ce_n == e.ce_n, e.tag, "ce_n (R6)", mem_ce_n, e.ce_n);
        check(mem_oe_n == e.oe_n, e.tag, "oe_n (R1)", mem_oe_n, e.oe_n);
        check(mem_we_n == e.we_n, e.tag, "we_n (R2)", mem_we_n, e.we_n);
        check(mem_dq_oe == e.dq_oe, e.tag, "dq_oe (R5)", mem_dq_oe, e.dq_oe);
        check(req_ready == e.ready, e.tag, "ready (R7)", req_ready, e.ready);
        check(rsp_valid == e.rsp, e.tag, "rsp_valid (R3)", rsp_valid, e.rsp);
        if (!e.ce_n) check(mem_addr == e.addr, "R6", "address", mem_addr, e.addr);
        if (e.dq_oe) check(mem_dq_out == e.wdata, "R5", "write data", mem_dq_out, e.wdata);
        if (e.rsp)   check(rsp_rdata == e.rdata, "R3", "read data", rsp_rdata, e.rdata);
    endtask

    always @(negedge clk) begin
        exp_t e;
        bit   mem_drv;
        if (rst) begin
            q.delete();
            mcfg = CFG_RESET;
            m_last_rd = 0;
            oe_cnt = 0;
            off_cnt = 0;
            mem_dq_in = 16'hBAD0;
        end else begin
            e = (q.size() > 0) ? q.pop_front() : idle_e();
            compare(e);
            if (req_valid && req_ready) push_access(req_write, req_addr, req_wdata);
            if (cfg_wr) mcfg = asram_cfg_t'(cfg_data);
            // memory model: bus contention (R4), data access delay, write capture
            mem_drv = (!mem_ce_n && !mem_oe_n) || (off_cnt > 0);
            check(!(mem_drv && mem_dq_oe), "R4", "bus contention", int'(mem_drv), 0);
            if (!mem_ce_n && !mem_oe_n) off_cnt = MEM_OFF;
            else if (off_cnt > 0) off_cnt--;
            if (!mem_ce_n && !mem_we_n) sram[mem_addr[3:0]] = mem_dq_out;
            if (!mem_ce_n && !mem_oe_n) begin
                oe_cnt++;
                mem_dq_in = (oe_cnt > MEM_ACC) ? sram[mem_addr[3:0]] : 16'hBAD0;
            end else begin
                oe_cnt = 0;
                mem_dq_in = 16'hBAD0;
            end
        end
    end

    function automatic asram_cfg_t mkcfg(int rsu, int rst_, int rhd, int wsu, int wst, int whd, int ta);
        asram_cfg_t c;
        c.rd.setup = rsu[3:0]; c.rd.strobe = rst_[3:0]; c.rd.hold = rhd[3:0];
        c.wr.setup = wsu[3:0]; c.wr.strobe = wst[3:0]; c.wr.hold = whd[3:0];
        c.turn = ta[3:0];
        return c;
    endfunction

    task automatic cfg_write(asram_cfg_t c);
        cfg_wr = 1; cfg_data = c;
        @(posedge clk); #1;
        cfg_wr = 0;
    endtask

    task automatic wait_idle();
        while (!req_ready) begin @(posedge clk); #1; end
    endtask

    task automatic go(bit wr, logic [15:0] a, logic [15:0] d);
        wait_idle();
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic acc(bit wr, logic [15:0] a, logic [15:0] d);
        go(wr, a, d);
        wait_idle();
    endtask

    task automatic finish_run();
        repeat (4) @(posedge clk);
        #1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin ref_mem[i] = '0; sram[i] = '0; end
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R9: outputs while reset is held
        check(mem_ce_n && mem_oe_n && mem_we_n, "R9", "strobes idle in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        check(!mem_dq_oe && req_ready && !rsp_valid, "R9", "driver/ready/rsp in reset", {mem_dq_oe, req_ready, rsp_valid}, 2);
        @(posedge clk); #1;
        rst = 0;

        scen = "R8 reset timing";
        acc(1, 16'h0001, 16'h1111);
        acc(0, 16'h0001, 16'h0);

        scen = "R1 R2 mixed";
        cfg_write(mkcfg(1, 2, 1, 0, 1, 0, 1));
        acc(1, 16'h0002, 16'h2222);
        acc(0, 16'h0002, 16'h0);
        acc(0, 16'h0001, 16'h0);
        scen = "R4 read then write";
        acc(1, 16'h0003, 16'h3333);
        acc(1, 16'h0004, 16'h4444);
        acc(0, 16'h0003, 16'h0);

        scen = "R3 short strobe";
        cfg_write(mkcfg(0, 0, 0, 0, 0, 0, 0));
        acc(0, 16'h0004, 16'h0);
        acc(1, 16'h0005, 16'h5555);

        scen = "R3 exact strobe";
        cfg_write(mkcfg(0, 2, 0, 2, 0, 3, 0));
        acc(0, 16'h0005, 16'h0);
        scen = "R7 back to back";
        go(0, 16'h0002, 16'h0);
        go(1, 16'h0006, 16'h6666);
        go(0, 16'h0006, 16'h0);
        wait_idle();

        scen = "R4 long turnaround";
        cfg_write(mkcfg(3, 4, 2, 1, 2, 1, 6));
        acc(0, 16'h0006, 16'h0);
        acc(1, 16'h0007, 16'h7777);
        acc(0, 16'h0007, 16'h0);

        scen = "R8 change mid access";
        go(0, 16'h0004, 16'h0);
        @(posedge clk); #1;
        cfg_write(mkcfg(0, 5, 3, 0, 0, 0, 2));
        wait_idle();
        acc(0, 16'h0005, 16'h0);
        acc(1, 16'h0008, 16'h8888);
        acc(0, 16'h0008, 16'h0);

        finish_run();
    end

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL R7 watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule